// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block runs the power-down mode of a small processor core. When the core signals that it has executed its sleep instruction, the block holds the core, gates the oscillator and the timer channels, and sends a one-cycle clear to the watchdog, which keeps counting. If an analog-to-digital conversion is in progress at that moment, the oscillator and the timers are left running so that the conversion can finish. The watchdog is still cleared.

While the core is held, the block watches six wake sources. Two of them, the external reset pin and a watchdog time-out, end in a full core reset. They also record the cause in two status flags: `flag_t` marks a watchdog cause and `flag_p` marks a reset that arrived during power-down. The other four sources are a port-pin change, a comparator change, a conversion-done strobe and a low-voltage event. These let the program continue. The program either branches to a fixed vector or resumes after the sleep instruction, depending on whether interrupts were globally enabled when sleep began. Before the core is released, a stabilisation delay runs. Its length is chosen by the oscillator mode. Enabling the watchdog masks every continue-class wake enable.

All pins are plain control and status levels or strobes. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `slpwk_ctrl`

## Requirements
- R1: After `rst_n` is released, `flag_t`, `flag_p`, `wake_en_eff` and every pulse output read 0, `core_hold` is 0, and `osc_run` and all `tmr_run` bits are 1.
- R2: `pin_rst`, or `wdt_tmo` while `wdt_en` is 1, causes a reset event. When awake, `core_reset` pulses in the next cycle with `flag_p`=0. When asleep, `core_reset` and `core_release` pulse together after the settle delay with `flag_p`=1. In both cases `flag_t` is 1 for a watchdog cause and 0 for a pin cause.
- R3: Continue-class wake sources are gated by the wake-enable bits written through `wen_wr`/`wen_wdata`: bit 0 enables a port change (`port_in` differs from its value at sleep entry), bit 1 enables a comparator change (`cmp_out` differs from its entry value), bit 2 enables `adc_done`, and bit 3 enables `lvd_evt`. A continue-class wake pulses `core_release` without `core_reset`. A source whose bit is 0 does not wake the core.
- R4: If `gie` was 1 at sleep entry, `rel_branch`=1 with the release and `rel_vector` is 0x06 for a port wake, 0x0F for a comparator wake and 0x0C for a conversion-done wake. A low-voltage wake, or any wake with `gie`=0 at entry, gives `rel_branch`=0 and `rel_vector`=0.
- R5: The cycle after `sleep_req` is accepted, `core_hold`=1, `osc_run`=0 and all `tmr_run` bits are 0, and `wdt_clr` is 1 for exactly that one cycle.
- R6: If `adc_busy` is 1 at sleep entry, `osc_run` and `tmr_run` stay 1 throughout the sleep, and the settle delay is one cycle.
- R7: While `wdt_en` is 1, `wake_en_eff` reads 0 and no continue-class source wakes the core. The stored enables return on `wake_en_eff` when `wdt_en` falls.
- R8: The settle delay is D cycles after the edge that detects the wake, where D is RC_CYC for `osc_mode` 0 or 3, RC_CYC+HXT_CYC for mode 1 and LXT_CYC for mode 2. During the delay `osc_run`=1, the timers are off and `core_hold`=1. `core_hold` falls with the release.
- R9: When sources coincide, the priority is pin reset, then watchdog, then port change, then comparator, then conversion done, then low voltage.
- R10: `sleep_req` has no effect while the core is held: no `wdt_clr` pulse and no change to the wake in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| sleep_req | input | 1 | Strobe from the core: sleep instruction executed |
| gie | input | 1 | Global interrupt enable level from the core |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_tmo | input | 1 | Watchdog time-out strobe |
| pin_rst | input | 1 | External reset pin event |
| osc_mode | input | 2 | 0 RC, 1 fast crystal, 2 slow crystal, 3 treated as RC |
| adc_busy | input | 1 | Conversion in progress |
| adc_done | input | 1 | Conversion complete strobe |
| cmp_out | input | 1 | Comparator output level |
| lvd_evt | input | 1 | Low-voltage detector strobe |
| port_in | input | PW | Port pin levels |
| wen_wr | input | 1 | Write strobe for the wake-enable bits |
| wen_wdata | input | 4 | Wake-enable write data {lvd, adc, cmp, port} |
| wake_en_eff | output | 4 | Wake enables after watchdog masking |
| core_hold | output | 1 | Core stalled |
| osc_run | output | 1 | Oscillator enable |
| tmr_run | output | NT | Per-timer run enables |
| wdt_clr | output | 1 | Watchdog clear pulse |
| core_release | output | 1 | Pulse: core leaves power-down |
| core_reset | output | 1 | Pulse: full core reset |
| rel_branch | output | 1 | With release: jump to `rel_vector` |
| rel_vector | output | VW | Branch target, valid with `rel_branch` |
| flag_t | output | 1 | Last reset caused by the watchdog |
| flag_p | output | 1 | Last reset arrived during power-down |

## Verification
The bench sends each wake source into a sleep that was entered with interrupts on and with interrupts off. This separates a branch to the vector from a plain resume, and the vector values show that each source was classified correctly. The same wake is run under each oscillator mode and with a conversion busy at entry, so an exact cycle count of the release distinguishes the delay that was chosen. Some runs fire sources together, mask a source, or have the watchdog enabled. These show the priority order and the masking, and the pin-versus-watchdog runs, awake and asleep, tell the two status flags apart.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;
  localparam int NWK  = 4;  // continue-class wake enable bits
  localparam int NSRC = 6;  // total wake sources

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_SETTLE = 2'd2
  } slp_st_t;

  // encoding order is the priority order (lower value wins)
  typedef enum logic [2:0] {
    WK_NONE = 3'd0,
    WK_PIN  = 3'd1,
    WK_WDT  = 3'd2,
    WK_PORT = 3'd3,
    WK_CMP  = 3'd4,
    WK_ADC  = 3'd5,
    WK_LVD  = 3'd6
  } wk_kind_t;

  function automatic logic is_reset_kind(wk_kind_t k);
    return (k == WK_PIN) || (k == WK_WDT);
  endfunction

  function automatic logic is_vectored_kind(wk_kind_t k);
    return (k == WK_PORT) || (k == WK_CMP) || (k == WK_ADC);
  endfunction
endpackage

// File: rtl/slpwk_wake_det.sv
module slpwk_wake_det
  import slpwk_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic [PW-1:0]  port_in,
  input  logic           cmp_in,
  input  logic           pin_hit,
  input  logic           wdt_hit,
  input  logic           adc_done,
  input  logic           lvd_evt,
  input  logic [NWK-1:0] wen,
  output wk_kind_t       kind
);
  logic [PW-1:0]   port_snap;
  logic            cmp_snap;
  logic [NSRC-1:0] hit;

  // levels seen when sleep starts; later differences are wake events
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_snap <= '0;
      cmp_snap  <= 1'b0;
    end else if (capture) begin
      port_snap <= port_in;
      cmp_snap  <= cmp_in;
    end
  end

  always_comb begin
    hit    = '0;
    hit[0] = pin_hit;
    hit[1] = wdt_hit;
    hit[2] = wen[0] && (port_in != port_snap);
    hit[3] = wen[1] && (cmp_in != cmp_snap);
    hit[4] = wen[2] && adc_done;
    hit[5] = wen[3] && lvd_evt;
  end

  // walk from lowest to highest priority so the winner is written last
  always_comb begin
    kind = WK_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hit[i]) kind = wk_kind_t'(3'(i + 1));
    end
  end
endmodule

// File: rtl/slpwk_settle.sv
module slpwk_settle #(
  parameter int RC_CYC  = 32,
  parameter int HXT_CYC = 100,
  parameter int LXT_CYC = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       fast,
  input  logic [1:0] osc_mode,
  output logic       expire
);
  localparam int MAX_A = (RC_CYC + HXT_CYC > LXT_CYC) ? RC_CYC + HXT_CYC : LXT_CYC;
  localparam int CW    = $clog2(MAX_A + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] dly;

  always_comb begin
    if (fast) begin
      dly = CW'(1);
    end else begin
      case (osc_mode)
        2'd1:    dly = CW'(RC_CYC + HXT_CYC);
        2'd2:    dly = CW'(LXT_CYC);
        default: dly = CW'(RC_CYC);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= dly;
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign expire = (cnt == CW'(1));
endmodule

// File: rtl/slpwk_ctrl.sv
module slpwk_ctrl
  import slpwk_pkg::*;
#(
  parameter int          PW       = 8,
  parameter int          NT       = 4,
  parameter int          VW       = 8,
  parameter int          RC_CYC   = 32,
  parameter int          HXT_CYC  = 100,
  parameter int          LXT_CYC  = 400,
  parameter logic [VW-1:0] VEC_PORT = 8'h06,
  parameter logic [VW-1:0] VEC_CMP  = 8'h0F,
  parameter logic [VW-1:0] VEC_ADC  = 8'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic          gie,
  input  logic          wdt_en,
  input  logic          wdt_tmo,
  input  logic          pin_rst,
  input  logic [1:0]    osc_mode,
  input  logic          adc_busy,
  input  logic          adc_done,
  input  logic          cmp_out,
  input  logic          lvd_evt,
  input  logic [PW-1:0] port_in,
  input  logic          wen_wr,
  input  logic [3:0]    wen_wdata,
  output logic [3:0]    wake_en_eff,
  output logic          core_hold,
  output logic          osc_run,
  output logic [NT-1:0] tmr_run,
  output logic          wdt_clr,
  output logic          core_release,
  output logic          core_reset,
  output logic          rel_branch,
  output logic [VW-1:0] rel_vector,
  output logic          flag_t,
  output logic          flag_p
);
  slp_st_t       st;
  wk_kind_t      det_kind;
  wk_kind_t      pend;
  logic [NWK-1:0] wen_r;
  logic          keep_clk;
  logic          gie_s;
  logic          wdt_ev;
  logic          rst_ev;
  logic          capture;
  logic          wake_hit;
  logic          expire;
  logic          tmr_on;
  logic [VW-1:0] vec_sel;

  assign wdt_ev   = wdt_en && wdt_tmo;
  assign rst_ev   = pin_rst || wdt_ev;
  assign capture  = (st == ST_RUN) && sleep_req && !rst_ev;
  assign wake_hit = (st == ST_SLEEP) && (det_kind != WK_NONE);

  // wake enables: stored as written, masked while the watchdog runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wen_r <= '0;
    else if (wen_wr) wen_r <= wen_wdata;
  end
  assign wake_en_eff = wdt_en ? '0 : wen_r;

  slpwk_wake_det #(.PW(PW)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .port_in  (port_in),
    .cmp_in   (cmp_out),
    .pin_hit  (pin_rst),
    .wdt_hit  (wdt_ev),
    .adc_done (adc_done),
    .lvd_evt  (lvd_evt),
    .wen      (wake_en_eff),
    .kind     (det_kind)
  );

  slpwk_settle #(.RC_CYC(RC_CYC), .HXT_CYC(HXT_CYC), .LXT_CYC(LXT_CYC)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wake_hit),
    .fast     (keep_clk),
    .osc_mode (osc_mode),
    .expire   (expire)
  );

  always_comb begin
    case (pend)
      WK_PORT: vec_sel = VEC_PORT;
      WK_CMP:  vec_sel = VEC_CMP;
      WK_ADC:  vec_sel = VEC_ADC;
      default: vec_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_RUN;
      pend         <= WK_NONE;
      keep_clk     <= 1'b0;
      gie_s        <= 1'b0;
      wdt_clr      <= 1'b0;
      core_release <= 1'b0;
      core_reset   <= 1'b0;
      rel_branch   <= 1'b0;
      rel_vector   <= '0;
      flag_t       <= 1'b0;
      flag_p       <= 1'b0;
    end else begin
      wdt_clr      <= 1'b0;
      core_release <= 1'b0;
      core_reset   <= 1'b0;
      rel_branch   <= 1'b0;
      rel_vector   <= '0;
      unique case (st)
        ST_RUN: begin
          if (rst_ev) begin
            core_reset <= 1'b1;
            flag_t     <= !pin_rst;
            flag_p     <= 1'b0;
          end else if (sleep_req) begin
            st       <= ST_SLEEP;
            keep_clk <= adc_busy;
            gie_s    <= gie;
            wdt_clr  <= 1'b1;
          end
        end
        ST_SLEEP: begin
          if (wake_hit) begin
            st   <= ST_SETTLE;
            pend <= det_kind;
          end
        end
        ST_SETTLE: begin
          if (expire) begin
            st           <= ST_RUN;
            keep_clk     <= 1'b0;
            core_release <= 1'b1;
            if (is_reset_kind(pend)) begin
              core_reset <= 1'b1;
              flag_t     <= (pend == WK_WDT);
              flag_p     <= 1'b1;
            end else if (gie_s && is_vectored_kind(pend)) begin
              rel_branch <= 1'b1;
              rel_vector <= vec_sel;
            end
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign core_hold = (st != ST_RUN);
  assign osc_run   = (st != ST_SLEEP) || keep_clk;
  assign tmr_on    = (st == ST_RUN) || keep_clk;

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    assign tmr_run[g] = tmr_on;
  end
endmodule

// File: rtl/slpwk_ctrl_chk.sv
module slpwk_ctrl_chk #(
  parameter int            NT       = 4,
  parameter int            VW       = 8,
  parameter logic [VW-1:0] VEC_PORT = 8'h06,
  parameter logic [VW-1:0] VEC_CMP  = 8'h0F,
  parameter logic [VW-1:0] VEC_ADC  = 8'h0C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_hold,
  input logic          osc_run,
  input logic [NT-1:0] tmr_run,
  input logic          wdt_clr,
  input logic          core_release,
  input logic          core_reset,
  input logic          rel_branch,
  input logic [VW-1:0] rel_vector,
  input logic          flag_t
);
  // R5: each entry into power-down clears the watchdog
  p_entry_clears_wdt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_hold) |-> wdt_clr);

  // R8: a release only ends a held period and frees the core
  p_release_after_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_release |-> ($past(core_hold) && !core_hold));

  // R4: a branch comes with a release and one of the three vectors
  p_vector_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_branch |-> (core_release &&
      (rel_vector == VEC_PORT || rel_vector == VEC_CMP || rel_vector == VEC_ADC)));

  // R2: a full reset never branches to a vector
  p_reset_no_branch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |-> !rel_branch);

  // R2: the watchdog flag only rises with a reset
  p_tflag_with_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_t) |-> core_reset);

  // R6: with the oscillator gated, every timer is gated too
  p_timers_follow_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_hold && !osc_run) |-> (tmr_run == '0));
endmodule

bind slpwk_ctrl slpwk_ctrl_chk #(
  .NT(NT), .VW(VW), .VEC_PORT(VEC_PORT), .VEC_CMP(VEC_CMP), .VEC_ADC(VEC_ADC)
) u_chk (.*);

// File: tb/slpwk_ctrl_bench.sv
module slpwk_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int NT = 4;
  localparam int VW = 8;
  localparam int RC = 32, HX = 100, LX = 400;

  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, gie = 0, wdt_en = 0, wdt_tmo = 0, pin_rst = 0;
  logic [1:0] osc_mode = 0;
  logic adc_busy = 0, adc_done = 0, cmp_out = 0, lvd_evt = 0;
  logic [PW-1:0] port_in = 8'h5A;
  logic wen_wr = 0;
  logic [3:0] wen_wdata = 0;
  logic [3:0] wake_en_eff;
  logic core_hold, osc_run, wdt_clr, core_release, core_reset, rel_branch, flag_t, flag_p;
  logic [NT-1:0] tmr_run;
  logic [VW-1:0] rel_vector;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slpwk_ctrl u_slpwk_ctrl (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference, one step per clock ----------------
  int m_st, m_cnt, m_kind, m_wen;
  bit m_keep, m_gie, m_c, m_clr, m_rel, m_rst, m_br, m_t, m_p;
  int m_psnap, m_vec;

  function automatic int dly_of(int mode, bit keep);
    if (keep) return 1;
    if (mode == 1) return RC + HX;
    if (mode == 2) return LX;
    return RC;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_kind = 0; m_wen = 0; m_keep = 0; m_gie = 0;
      m_c = 0; m_psnap = 0; m_clr = 0; m_rel = 0; m_rst = 0; m_br = 0;
      m_vec = 0; m_t = 0; m_p = 0;
    end else begin
      int eff;
      bit w;
      eff = wdt_en ? 0 : m_wen;
      w = wdt_en && wdt_tmo;
      m_clr = 0; m_rel = 0; m_rst = 0; m_br = 0; m_vec = 0;
      if (m_st == 0) begin
        if (pin_rst || w) begin
          m_rst = 1; m_t = !pin_rst; m_p = 0;
        end else if (sleep_req) begin
          m_st = 1; m_psnap = port_in; m_c = cmp_out;
          m_keep = adc_busy; m_gie = gie; m_clr = 1;
        end
      end else if (m_st == 1) begin
        int k;
        k = 0;
        if (eff[3] && lvd_evt) k = 6;
        if (eff[2] && adc_done) k = 5;
        if (eff[1] && cmp_out != m_c) k = 4;
        if (eff[0] && int'(port_in) != m_psnap) k = 3;
        if (w) k = 2;
        if (pin_rst) k = 1;
        if (k != 0) begin
          m_st = 2; m_kind = k; m_cnt = dly_of(osc_mode, m_keep);
        end
      end else begin
        if (m_cnt == 1) begin
          m_st = 0; m_keep = 0; m_rel = 1;
          if (m_kind <= 2) begin
            m_rst = 1; m_t = (m_kind == 2); m_p = 1;
          end else if (m_gie && m_kind <= 5) begin
            m_br = 1;
            m_vec = (m_kind == 3) ? 'h06 : (m_kind == 4) ? 'h0F : 'h0C;
          end
        end else m_cnt--;
      end
      if (wen_wr) m_wen = wen_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(core_hold == (m_st != 0), "R5 core_hold vs model", core_hold, m_st != 0);
      chk(osc_run == (m_st != 1 || m_keep), "R6 osc_run vs model", osc_run, (m_st != 1 || m_keep));
      chk(tmr_run == ((m_st == 0 || m_keep) ? '1 : '0), "R8 tmr_run vs model", tmr_run, (m_st == 0 || m_keep));
      chk(wdt_clr == m_clr, "R5 wdt_clr vs model", wdt_clr, m_clr);
      chk(core_release == m_rel, "R3 core_release vs model", core_release, m_rel);
      chk(core_reset == m_rst, "R2 core_reset vs model", core_reset, m_rst);
      chk(rel_branch == m_br && int'(rel_vector) == m_vec, "R4 branch/vector vs model", rel_vector, m_vec);
      chk(flag_t == m_t && flag_p == m_p, "R2 flags vs model", {flag_t, flag_p}, {m_t, m_p});
      chk(int'(wake_en_eff) == (wdt_en ? 0 : m_wen), "R7 wake_en_eff vs model", wake_en_eff, wdt_en ? 0 : m_wen);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic set_wen(input logic [3:0] v);
    @(negedge clk); wen_wr = 1; wen_wdata = v;
    @(negedge clk); wen_wr = 0;
  endtask

  task automatic go_sleep(input logic g, input logic busy);
    @(negedge clk); gie = g; adc_busy = busy; sleep_req = 1;
    @(negedge clk); sleep_req = 0; adc_busy = 0;
  endtask

  // src: 0 port toggle, 1 cmp toggle, 2 adc_done, 3 lvd, 4 wdt, 5 pin, 6 port+adc
  task automatic wake(input int src, output int n);
    case (src)
      0: port_in = ~port_in;
      1: cmp_out = ~cmp_out;
      2: adc_done = 1;
      3: lvd_evt = 1;
      4: wdt_tmo = 1;
      5: pin_rst = 1;
      default: begin port_in = ~port_in; adc_done = 1; end
    endcase
    n = 0;
    while (n < 1000) begin
      @(negedge clk); n++;
      adc_done = 0; lvd_evt = 0; wdt_tmo = 0; pin_rst = 0;
      if (core_release) break;
    end
  endtask

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(flag_t == 0 && flag_p == 0, "R1 flags after reset", {flag_t, flag_p}, 0);
    chk(wake_en_eff == 0, "R1 wake enables after reset", wake_en_eff, 0);
    chk(!core_hold && osc_run && tmr_run == '1, "R1 core free clocks on", {core_hold, osc_run}, 1);

    set_wen(4'hF);
    chk(wake_en_eff == 4'hF, "R7 enables visible with watchdog off", wake_en_eff, 15);

    // R5 entry, R4 port vector, R8 RC delay
    go_sleep(1, 0);
    chk(core_hold && !osc_run && tmr_run == 0 && wdt_clr, "R5 entry gating and wdt clear", {core_hold, osc_run, wdt_clr}, 5);
    // R10 second request while asleep
    sleep_req = 1; @(negedge clk); sleep_req = 0;
    chk(!wdt_clr && core_hold, "R10 sleep_req ignored while held", wdt_clr, 0);
    wake(0, n);
    chk(n == RC + 1, "R8 RC settle cycles", n, RC + 1);
    chk(rel_branch && rel_vector == 8'h06 && !core_reset, "R4 port vector", rel_vector, 6);

    // R4 comparator vector with R6 busy converter
    go_sleep(1, 1);
    chk(osc_run && tmr_run == '1, "R6 clocks kept during conversion", osc_run, 1);
    wake(1, n);
    chk(n == 2, "R6 one-cycle settle", n, 2);
    chk(rel_branch && rel_vector == 8'h0F, "R4 comparator vector", rel_vector, 15);

    go_sleep(1, 0);
    wake(2, n);
    chk(rel_branch && rel_vector == 8'h0C, "R4 conversion-done vector", rel_vector, 12);

    go_sleep(1, 0);
    wake(3, n);
    chk(core_release && !rel_branch && !core_reset, "R4 low-voltage resumes without vector", rel_branch, 0);

    // R4 gie off, R8 fast-crystal delay
    osc_mode = 1;
    go_sleep(0, 0);
    wake(0, n);
    chk(n == RC + HX + 1, "R8 fast-crystal settle cycles", n, RC + HX + 1);
    chk(core_release && !rel_branch && rel_vector == 0, "R4 resume when interrupts off", rel_branch, 0);

    osc_mode = 2;
    go_sleep(1, 0);
    wake(3, n);
    chk(n == LX + 1, "R8 slow-crystal settle cycles", n, LX + 1);
    osc_mode = 0;

    // R9 simultaneous port change and conversion done
    go_sleep(1, 0);
    wake(6, n);
    chk(rel_vector == 8'h06, "R9 port beats conversion-done", rel_vector, 6);

    // R3 masked port source
    set_wen(4'hE);
    go_sleep(1, 0);
    port_in = ~port_in;
    repeat (40) @(negedge clk);
    chk(core_hold && !core_release, "R3 disabled port change does not wake", core_hold, 1);
    wake(1, n);
    chk(rel_vector == 8'h0F, "R3 enabled comparator wakes", rel_vector, 15);
    set_wen(4'hF);

    // R7 watchdog masking, then R2 watchdog wake
    wdt_en = 1;
    @(negedge clk);
    chk(wake_en_eff == 0, "R7 enables masked by watchdog", wake_en_eff, 0);
    go_sleep(1, 0);
    port_in = ~port_in; cmp_out = ~cmp_out;
    repeat (50) @(negedge clk);
    chk(core_hold, "R7 continue sources blocked under watchdog", core_hold, 1);
    wake(4, n);
    chk(n == RC + 1 && core_reset && core_release, "R2 watchdog wake resets", n, RC + 1);
    chk(flag_t && flag_p, "R2 watchdog cause flags", {flag_t, flag_p}, 3);
    wdt_en = 0;
    @(negedge clk);
    chk(wake_en_eff == 4'hF, "R7 enables return", wake_en_eff, 15);

    // R2 pin wake while asleep, with R9 pin beating port
    go_sleep(1, 0);
    wake(5, n);
    chk(core_reset && !flag_t && flag_p, "R2 pin wake flags", {flag_t, flag_p}, 1);

    go_sleep(1, 0);
    pin_rst = 1; port_in = ~port_in;
    @(negedge clk); pin_rst = 0;
    wake(3, n);
    chk(core_reset && !rel_branch, "R9 pin beats port change", core_reset, 1);

    // R2 pin while running
    @(negedge clk); pin_rst = 1;
    @(negedge clk); pin_rst = 0;
    chk(core_reset && !flag_t && !flag_p && !core_hold, "R2 pin reset while awake", {flag_t, flag_p}, 0);
    @(negedge clk); wdt_en = 1; wdt_tmo = 1;
    @(negedge clk); wdt_tmo = 0; wdt_en = 0;
    chk(core_reset && flag_t && !flag_p, "R2 watchdog reset while awake", {flag_t, flag_p}, 2);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule